// File: doc/BRIEF.md
# Streaming Prefix-Code Decoder

This unit decodes a single variable-length prefix code, one bit per clock. Its code table is one 64-bit bitmap. A code is turned into a table position by starting a running value at 1 and shifting each code bit in at the bottom. For example, code "10" lands on position 0b110. The code is complete once the bitmap holds a 1 at that position. Codes are at most five bits long, so they use positions 2 to 63. The two lowest table bits are free, and they carry a 2-bit mode.

Input bits come from a leftover word and, optionally, from a fresh 64-bit word. The leftover word holds its bits under a single marker 1, and bits are taken from the least significant end. When the leftover bits run out and the fresh word is allowed, all 64 fresh bits are loaded behind a new marker and the walk continues. The unit returns the decoded value, the updated leftover word in the same marker form, and four flags. Software can feed the returned word straight back in for the next decode.

A one-cycle `start` samples all inputs. `busy` stays high while the walk runs, and `done` then pulses for one cycle. The outputs hold until the next decode finishes.

Top module: `pfx_decode_unit`

## Requirements
- R1: After reset, busy, done and starved are 0, result and flags are 0, and left_out is 1.
- R2: With table bit 0 clear, a matched code gives result equal to its marker-prefixed position: 1, followed by the code bits, first bit most significant.
- R3: With table bit 0 set, a matched code gives result equal to the number of 1 bits in the table at positions from 2 up to one below the matched position.
- R4: Leftover bits are taken least significant first, and the returned left_out holds the unused bits under one marker 1. left_word = 1 means no bits are left.
- R5: When the leftover bits are exhausted and fresh_ok is 1, the walk continues with fresh_word bit 0 first. left_out then carries the unused fresh bits, and flags[3] (fresh word used) is 1.
- R6: If a bit is needed and none is available, the decode ends with starved = 1, result 0, flags = 4'b0010, and left_out equal to the original left_word.
- R7: With table bit 1 clear, if no code of five bits or fewer matches, the decode ends with result 0, flags = 4'b0011, starved 0, and left_out equal to the original left_word.
- R8: With table bit 1 set and no match in five bits, a sixth bit is consumed and result = 64 + the six bits (first bit most significant). flags[0] (overflow) is 1 and left_out is updated.
- R9: busy is high for exactly as many cycles as bits are consumed (one more for a starved decode, at most 6), starting the cycle after start. done follows for exactly one cycle.
- R10: A start while busy is high is ignored and does not change the decode in progress.
- R11: flags[2] is always 0, and flags[1] is 1 exactly when result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sample inputs and begin a decode |
| table_word | input | 64 | Code bitmap; bit 0 selects compressed output, bit 1 the raw fallback |
| left_word | input | 64 | Leftover bits under a marker 1 |
| fresh_word | input | 64 | Next stream word |
| fresh_ok | input | 1 | fresh_word may be consumed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Decoded value |
| left_out | output | 64 | Updated leftover word |
| flags | output | 4 | {fresh used, 0, result is zero, overflow} |
| starved | output | 1 | Input ran out before the decode finished |

## Verification
A wrong position register or a wrong bit-source register does not stay hidden. It changes the length of the walk, so the busy/done timing slips on the very decode where it happens. It also changes result and left_out in the done cycle of that same decode. A stale fresh-used state would show in flags[3] and in a truncated or repeated left_out. The reference model compares busy and done on every clock, so a cycle-count error is caught in the cycle where it first occurs.

// File: rtl/pfx_pkg.sv
// Shared types for the prefix-code decoder.
// Assumes: one decode in flight at a time.
package pfx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_DONE
    } pfx_state_e;

    typedef enum logic [2:0] {
        OUT_CONT,
        OUT_STARVE,
        OUT_MATCH,
        OUT_FAIL,
        OUT_RAW
    } pfx_outcome_e;

    // Mode bit positions inside the table word
    localparam int MODE_COMP = 0;
    localparam int MODE_RAW  = 1;

endpackage

// File: rtl/pfx_bit_feed.sv
// Bit source: delivers the next stream bit from the marker-form
// current word, or reloads it from the fresh word when it is empty.
// Assumes: cur holds a marker 1 above its data bits (width DATA_W+1).
module pfx_bit_feed #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W:0]   cur,
    input  logic [DATA_W-1:0] fresh,
    input  logic              fresh_ok,
    output logic              bit_ok,
    output logic              bit_val,
    output logic              refill,
    output logic [DATA_W:0]   nxt
);

    logic             empty;
    logic [DATA_W:0]  src;

    // Pick the bit source and shift it down by one
    always_comb begin
        empty   = (cur[DATA_W:1] == '0);
        refill  = empty && fresh_ok;
        src     = refill ? {1'b1, fresh} : cur;
        bit_ok  = !empty || fresh_ok;
        bit_val = src[0];
        nxt     = src >> 1;
    end

endmodule

// File: rtl/pfx_rank.sv
// Rank counter: counts table bits set at positions 2 .. pos-1,
// which gives the compressed output value.
// Assumes: positions 0 and 1 hold mode bits and are never counted.
module pfx_rank #(
    parameter int DATA_W = 64,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] tbl,
    input  logic [LOG_W-1:0]  pos,
    output logic [LOG_W-1:0]  cnt
);

    logic [DATA_W-1:0] below;

    // One mask bit per table position
    for (genvar j = 0; j < DATA_W; j++) begin : g_mask
        if (j < 2) begin : g_mode
            assign below[j] = 1'b0;
        end else begin : g_code
            assign below[j] = tbl[j] && (LOG_W'(j) < pos);
        end
    end

    // Population count of the masked bits
    always_comb begin
        cnt = '0;
        for (int k = 0; k < DATA_W; k++) begin
            cnt = cnt + LOG_W'(below[k]);
        end
    end

endmodule

// File: rtl/pfx_decode_unit.sv
// Prefix-code decoder: walks one code bit per clock against a bitmap
// table, refills from a fresh word, and reports the result, the new
// leftover word and status flags.
// Assumes: start is only honoured when no walk is in progress;
// outputs hold between done pulses.
module pfx_decode_unit #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] table_word,
    input  logic [DATA_W-1:0] left_word,
    input  logic [DATA_W-1:0] fresh_word,
    input  logic              fresh_ok,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] left_out,
    output logic [3:0]        flags,
    output logic              starved
);
    import pfx_pkg::*;

    localparam int LOG_W   = $clog2(DATA_W);
    localparam int IDX_W   = LOG_W + 1;
    localparam int MAX_LEN = LOG_W - 1;
    localparam int RAW_LEN = LOG_W;
    localparam int LEN_W   = $clog2(RAW_LEN + 1);

    pfx_state_e        state_q;
    logic [DATA_W:0]   cur_q;
    logic [DATA_W-1:0] tbl_q;
    logic [DATA_W-1:0] fresh_q;
    logic              ok_q;
    logic [DATA_W-1:0] orig_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic              used_q;

    logic              bit_ok;
    logic              bit_val;
    logic              refill;
    logic [DATA_W:0]   nxt;
    logic [IDX_W-1:0]  idx_n;
    logic [LEN_W-1:0]  len_n;
    logic              hit;
    logic [LOG_W-1:0]  rank;
    logic [DATA_W-1:0] match_val;
    pfx_outcome_e      outcome;

    pfx_bit_feed #(.DATA_W(DATA_W)) u_feed (
        .cur      (cur_q),
        .fresh    (fresh_q),
        .fresh_ok (ok_q),
        .bit_ok   (bit_ok),
        .bit_val  (bit_val),
        .refill   (refill),
        .nxt      (nxt)
    );

    pfx_rank #(.DATA_W(DATA_W)) u_rank (
        .tbl (tbl_q),
        .pos (idx_n[LOG_W-1:0]),
        .cnt (rank)
    );

    // Next position, length and the outcome of this step
    always_comb begin
        idx_n = {idx_q[IDX_W-2:0], bit_val};
        len_n = len_q + 1'b1;
        hit   = (len_n <= LEN_W'(MAX_LEN)) && tbl_q[idx_n[LOG_W-1:0]];
        match_val = tbl_q[MODE_COMP] ? DATA_W'(rank) : DATA_W'(idx_n);
        if (!bit_ok) begin
            outcome = OUT_STARVE;
        end else if (hit) begin
            outcome = OUT_MATCH;
        end else if (len_n == LEN_W'(MAX_LEN) && !tbl_q[MODE_RAW]) begin
            outcome = OUT_FAIL;
        end else if (len_n == LEN_W'(RAW_LEN)) begin
            outcome = OUT_RAW;
        end else begin
            outcome = OUT_CONT;
        end
    end

    // Handshake outputs follow the state
    always_comb begin
        busy = (state_q == ST_WALK);
        done = (state_q == ST_DONE);
    end

    // Control state, walk registers and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            tbl_q    <= '0;
            fresh_q  <= '0;
            ok_q     <= 1'b0;
            orig_q   <= '0;
            idx_q    <= '0;
            len_q    <= '0;
            used_q   <= 1'b0;
            result   <= '0;
            left_out <= DATA_W'(1);
            flags    <= '0;
            starved  <= 1'b0;
        end else begin
            case (state_q)
                ST_WALK: begin
                    case (outcome)
                        OUT_CONT: begin
                            cur_q  <= nxt;
                            idx_q  <= idx_n;
                            len_q  <= len_n;
                            used_q <= used_q | refill;
                        end
                        OUT_STARVE: begin
                            result   <= '0;
                            left_out <= orig_q;
                            flags    <= 4'b0010;
                            starved  <= 1'b1;
                            state_q  <= ST_DONE;
                        end
                        OUT_FAIL: begin
                            result   <= '0;
                            left_out <= orig_q;
                            flags    <= 4'b0011;
                            starved  <= 1'b0;
                            state_q  <= ST_DONE;
                        end
                        OUT_MATCH: begin
                            result   <= match_val;
                            left_out <= nxt[DATA_W-1:0];
                            flags    <= {used_q | refill, 1'b0, match_val == '0, 1'b0};
                            starved  <= 1'b0;
                            state_q  <= ST_DONE;
                        end
                        default: begin
                            result   <= DATA_W'(idx_n);
                            left_out <= nxt[DATA_W-1:0];
                            flags    <= {used_q | refill, 3'b001};
                            starved  <= 1'b0;
                            state_q  <= ST_DONE;
                        end
                    endcase
                end
                default: begin
                    if (start) begin
                        cur_q   <= {1'b0, left_word};
                        tbl_q   <= table_word;
                        fresh_q <= fresh_word;
                        ok_q    <= fresh_ok;
                        orig_q  <= left_word;
                        idx_q   <= IDX_W'(1);
                        len_q   <= '0;
                        used_q  <= 1'b0;
                        state_q <= ST_WALK;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pfx_decode_checker.sv
// Protocol and result checks for the prefix-code decoder, bound to it.
// Assumes: only port-level signals of the unit are observed.
module pfx_decode_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] left_out,
    input logic [3:0]        flags,
    input logic              starved
);
    localparam int LOG_W   = $clog2(DATA_W);
    localparam int RAW_LEN = LOG_W;

    logic [3:0] busy_run;

    // Counts busy cycles already seen in the current walk
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < 4'(RAW_LEN)); // R9
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !done); // R9
    AST_STARVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && starved |-> result == '0 && flags == 4'b0010); // R6
    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && flags[0] && flags[1] |-> result == '0 && !flags[3]); // R7
    AST_RAW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done && flags[0] && !flags[1] |-> result[DATA_W-1:LOG_W] == 1); // R8
    AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flags[2]); // R11
    AST_LEFT_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> left_out != '0); // R4

endmodule

bind pfx_decode_unit pfx_decode_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .left_out (left_out),
    .flags    (flags),
    .starved  (starved)
);

// File: tb/pfx_decode_unit_bench.sv
// Bench: behavioural reference model, compared on every clock.
module pfx_decode_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] table_word = '0;
    logic [63:0] left_word = 64'd1;
    logic [63:0] fresh_word = '0;
    logic        fresh_ok = 1'b0;
    logic        busy, done, starved;
    logic [63:0] result, left_out;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    pfx_decode_unit u_pfx_decode_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .table_word(table_word), .left_word(left_word),
        .fresh_word(fresh_word), .fresh_ok(fresh_ok),
        .busy(busy), .done(done), .result(result),
        .left_out(left_out), .flags(flags), .starved(starved)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: bit queue, integer position, explicit outcome rules
    task automatic model(input logic [63:0] t, l, f, input bit ok,
                         output int ncyc, output logic [63:0] res, lo,
                         output logic [3:0] fl, output bit stv);
        bit q[$];
        logic [63:0] w;
        int nl, pos, len, idx, k, cnt;
        bit fin;
        w = l;
        while (w > 1) begin q.push_back(w[0]); w = w >> 1; end
        nl = q.size();
        if (ok) for (int i = 0; i < 64; i++) q.push_back(f[i]);
        idx = 1; len = 0; pos = 0; fin = 0;
        res = 0; lo = l; fl = 0; stv = 0; ncyc = 0;
        while (!fin) begin
            if (pos == q.size()) begin
                ncyc = pos + 1; res = 0; lo = l; fl = 4'b0010; stv = 1; fin = 1;
            end else begin
                idx = idx * 2 + q[pos]; pos++; len++;
                if (len <= 5 && t[idx]) begin
                    ncyc = len; fin = 1;
                    if (t[0]) begin
                        cnt = 0;
                        for (int j = 2; j < idx; j++) cnt += t[j];
                        res = cnt;
                    end else res = idx;
                    fl = {pos > nl, 1'b0, res == 0, 1'b0};
                end else if (len == 5 && !t[1]) begin
                    ncyc = 5; fin = 1; res = 0; lo = l; fl = 4'b0011;
                end else if (len == 6) begin
                    ncyc = 6; fin = 1; res = idx; fl = {pos > nl, 3'b001};
                end
                if (fin && !stv && !(fl[0] && fl[1])) begin
                    if (pos <= nl) lo = l >> pos;
                    else begin
                        k = pos - nl;
                        lo = (64'd1 << (64 - k)) | (f >> k);
                    end
                end
            end
        end
    endtask

    task automatic run(input logic [63:0] t, l, f, input bit ok, input bit poke, input string req);
        int n;
        logic [63:0] er, el;
        logic [3:0] ef;
        bit es;
        model(t, l, f, ok, n, er, el, ef, es);
        @(negedge clk);
        table_word = t; left_word = l; fresh_word = f; fresh_ok = ok; start = 1'b1;
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            start = poke && (c == 1);
            if (poke && c == 1) begin
                table_word = ~t; left_word = 64'hFF; fresh_word = ~f; fresh_ok = 1'b1;
            end
            chk(busy === 1'b1 && done === 1'b0, {req, " R9 busy phase"}, {busy, done}, 2'b10);
        end
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b0 && done === 1'b1, {req, " R9 done pulse"}, {busy, done}, 2'b01);
        chk(result === er, {req, " result"}, result, er);
        chk(left_out === el, {req, " left_out"}, left_out, el);
        chk(flags === ef, {req, " R11 flags"}, flags, ef);
        chk(starved === es, {req, " starved"}, starved, es);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, {req, " R9 idle after"}, {busy, done}, 2'b00);
    endtask

    localparam logic [63:0] TBL4 = 64'hC044; // codes 0,10,110,111

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && starved === 0, "R1 handshake reset", {busy, done, starved}, 0);
        chk(result === 0 && flags === 0, "R1 result reset", result, 0);
        chk(left_out === 64'd1, "R1 left reset", left_out, 1);
        rst_n = 1'b1;
        // R2 uncompressed, several codes
        run(TBL4, 64'b10, 0, 0, 0, "R2 code 0");
        run(TBL4, 64'b101, 0, 0, 0, "R2 code 10");
        run(TBL4, 64'b1011, 0, 0, 0, "R2 code 110");
        run(TBL4, 64'b1111_0111, 0, 0, 0, "R4 code 111 with spare bits");
        // R3 compressed
        run(TBL4 | 64'd1, 64'b1011, 0, 0, 0, "R3 compressed 110");
        run(TBL4 | 64'd1, 64'b10, 0, 0, 0, "R3 compressed 0");
        run(TBL4 | 64'd1, 64'b1111, 0, 0, 0, "R3 compressed 111");
        // R5 refill
        run(TBL4, 64'd1, 64'hDEAD_BEEF_0000_0003, 1, 0, "R5 refill from empty");
        run(TBL4, 64'b11, 64'hFFFF_0000_1234_5670, 1, 0, "R5 refill mid code");
        // R6 starved
        run(TBL4, 64'd1, 64'h5, 0, 0, "R6 empty no fresh");
        run(TBL4, 64'b111, 64'h5, 0, 0, "R6 partial no fresh");
        // R7 overflow without raw mode
        run(64'h0, 64'b1_0_1101, 0, 0, 0, "R7 no match");
        run(64'h8000_0000_0000_0000, 64'b10_1111, 0, 0, 0, "R7 near miss");
        run(64'h8000_0000_0000_0000, 64'b1_11111, 0, 0, 0, "R2 five bit code");
        // R8 raw fallback
        run(64'h2, 64'b1_101101, 0, 0, 0, "R8 raw six bits");
        run(64'h3, 64'b11_011001, 0, 0, 0, "R8 raw with compressed mode");
        run(64'h2, 64'b1_10110, 0, 0, 0, "R6 raw starves on sixth");
        run(64'h2, 64'b1_10110, 64'h1, 1, 0, "R8 raw refill sixth");
        // R10 start during busy
        run(TBL4, 64'b1111, 0, 0, 1, "R10 start while busy");
        run(64'h2, 64'b1_000000, 0, 0, 1, "R10 start while raw busy");
        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [63:0] t, l, f;
            int nb;
            t = {$urandom, $urandom};
            nb = $urandom_range(0, 9);
            l = (64'd1 << nb) | ({$urandom, $urandom} & ((64'd1 << nb) - 1));
            f = {$urandom, $urandom};
            run(t, l, f, $urandom_range(0, 1), $urandom_range(0, 3) == 0, "R2 R3 R4 R5 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule